// File: doc/BRIEF.md
# Selectable-Organization Scratchpad RAM

A small random-access read/write memory that sits on a shared data bus. Parameters choose one of three shapes (16 words of 4 bits, 256 words of 1 bit, or 1024 words of 1 bit), how many active-low select inputs must all be asserted, whether read data comes back true or complemented, and how the pins behave when the part is not driving. When not driving, a three-state build floats its data pins. An open-collector build pulls them to all ones instead, so a passive pull-up or another driver can own the line.

All activity is sampled on the rising clock edge. A write happens in a cycle where every select is low and the direction input is low. A read happens in a cycle where every select is low and the direction input is high. Read data and the driving indication appear one clock after the sampling edge. The storage is not reset. The one-bit-wide shapes keep their bits in a square matrix: the upper address half picks a row and the lower half picks a column.

Top module: `scratch_ram`

## Requirements
- R1: While reset is held, and until the internal reset release completes, `out_active` is 0. An open-collector build shows all ones on `dout` during this time.
- R2: The word at `addr` takes the value of `din` only when every bit of `cs_n` is 0 and `rw_n` is 0 at a rising edge. A selected cycle with `rw_n` = 1 leaves the contents unchanged.
- R3: After an edge where every `cs_n` bit is 0 and `rw_n` is 1, `out_active` is 1 in the following cycle and `dout` shows the word at the sampled address.
- R4: After an edge where `rw_n` is 0, `out_active` is 0 in the following cycle, whatever the selects are.
- R5: After an edge where any `cs_n` bit is 1, `out_active` is 0 in the following cycle, and no location changes even if `rw_n` is 0.
- R6: With the complement option set (the default, used with the 16x4 shape), `dout` is the bitwise inverse of the stored word. With it cleared, `dout` equals the stored word.
- R7: When `out_active` is 0, an open-collector build drives `dout` to all ones and a three-state build leaves `dout` at high impedance.
- R8: Every address selects its own location: the 16 words of the 4-bit shape, and the 256 locations of the row/column matrix of the 1-bit shape, all hold independent values.
- R9: A write uses the address and data present at its sampling edge, so writes on consecutive cycles to different addresses each land correctly.
- R10: Read data has exactly one clock of latency. `dout` does not change before the next edge when the address changes, and the output turns off one clock after deselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | NUM_EN | Active-low selects; all must be 0 to select |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | AW (4, 8 or 10) | Word address; upper half is row, lower half is column in 1-bit shapes |
| din | input | DW (4 or 1) | Write data |
| dout | output | DW | Read data, or the off level when not driving |
| out_active | output | 1 | 1 while `dout` carries read data |

## Verification
The hardest case to reach from the pins is a write attempt that must be blocked by a single raised select while the others stay low. Whether it succeeded only shows up later through a read. The stimulus raises each select of the three-select build alone during a write of the inverted value, then reads the location back with all selects low. A second case is exact one-clock latency. The address is changed in the middle of a read cycle and `dout` is sampled both before and after the next edge.

// File: rtl/scratch_ram_pkg.sv
package scratch_ram_pkg;

  typedef enum logic [1:0] {
    ORG_16X4   = 2'd0,
    ORG_256X1  = 2'd1,
    ORG_1024X1 = 2'd2
  } org_e;

  function automatic int org_addr_w(org_e o);
    case (o)
      ORG_16X4:   return 4;
      ORG_256X1:  return 8;
      default:    return 10;
    endcase
  endfunction

  function automatic int org_data_w(org_e o);
    case (o)
      ORG_16X4: return 4;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/scratch_ram_rst_sync.sv
module scratch_ram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_ok = stage_q[STAGES-1];

endmodule

// File: rtl/scratch_ram_select.sv
module scratch_ram_select #(
  parameter int NUM_EN = 1
) (
  input  logic [NUM_EN-1:0] cs_n,
  input  logic              rw_n,
  output logic              wr_stb,
  output logic              rd_stb
);

  logic chip_on;

  always_comb begin
    chip_on = ~|cs_n;
    wr_stb  = chip_on & ~rw_n;
    rd_stb  = chip_on & rw_n;
  end

endmodule

// File: rtl/scratch_ram_core.sv
module scratch_ram_core #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] rd_d;
  logic [DW-1:0] rd_q;

  if (DW == 1) begin : g_matrix
    localparam int COL_W = AW / 2;
    localparam int ROW_W = AW - COL_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [ROWS-1:0]  row_hit;
    logic [COLS-1:0]  mat_q [ROWS];
    logic [COLS-1:0]  row_word;

    assign row = addr[AW-1:COL_W];
    assign col = addr[COL_W-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_hit[r] = (row == ROW_W'(r));

      always_ff @(posedge clk) begin
        if (wr_stb && row_hit[r]) begin
          mat_q[r][col] <= din[0];
        end
      end
    end

    always_comb begin
      row_word = mat_q[row];
      rd_d     = row_word[col];
    end
  end else begin : g_words
    localparam int WORDS = 1 << AW;

    logic [WORDS-1:0] word_hit;
    logic [DW-1:0]    word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign word_hit[w] = (addr == AW'(w));

      always_ff @(posedge clk) begin
        if (wr_stb && word_hit[w]) begin
          word_q[w] <= din;
        end
      end
    end

    always_comb begin
      rd_d = word_q[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_stb) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/scratch_ram_out.sv
module scratch_ram_out #(
  parameter int DW        = 4,
  parameter bit INVERT_RD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic          rd_stb,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] pin_data,
  output logic          pin_drive
);

  logic drive_d;
  logic drive_q;

  always_comb begin
    drive_d = rd_stb;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive_d;
    end
  end

  if (INVERT_RD) begin : g_inv
    assign pin_data = ~rd_data;
  end else begin : g_true
    assign pin_data = rd_data;
  end

  assign pin_drive = drive_q;

endmodule

// File: rtl/scratch_ram.sv
module scratch_ram
  import scratch_ram_pkg::*;
#(
  parameter org_e ORG        = ORG_16X4,
  parameter int   NUM_EN     = 1,
  parameter bit   INVERT_RD  = 1'b1,
  parameter bit   OPEN_DRAIN = 1'b0,
  localparam int  AW         = org_addr_w(ORG),
  localparam int  DW         = org_data_w(ORG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EN-1:0] cs_n,
  input  logic              rw_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              out_active
);

  logic          rst_ok;
  logic          wr_stb;
  logic          rd_stb;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] pin_data;
  logic          pin_drive;

  scratch_ram_rst_sync #(
    .STAGES(2)
  ) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ok(rst_ok)
  );

  scratch_ram_select #(
    .NUM_EN(NUM_EN)
  ) i_select (
    .cs_n  (cs_n),
    .rw_n  (rw_n),
    .wr_stb(wr_stb),
    .rd_stb(rd_stb)
  );

  scratch_ram_core #(
    .AW(AW),
    .DW(DW)
  ) i_core (
    .clk    (clk),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .addr   (addr),
    .din    (din),
    .rd_data(rd_data)
  );

  scratch_ram_out #(
    .DW       (DW),
    .INVERT_RD(INVERT_RD)
  ) i_out (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .pin_data (pin_data),
    .pin_drive(pin_drive)
  );

  if (OPEN_DRAIN) begin : g_oc
    assign dout = pin_drive ? pin_data : {DW{1'b1}};
  end else begin : g_ts
    assign dout = pin_drive ? pin_data : {DW{1'bz}};
  end

  assign out_active = pin_drive;

endmodule

// File: rtl/scratch_ram_chk.sv
module scratch_ram_chk #(
  parameter int NUM_EN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic [NUM_EN-1:0] cs_n,
  input logic              rw_n,
  input logic              out_active
);

  AST_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> !out_active); // R1

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && rw_n && (cs_n == '0)) |=> out_active); // R3

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |=> !out_active); // R4

  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '0) |=> !out_active); // R5

endmodule

bind scratch_ram scratch_ram_chk #(
  .NUM_EN(NUM_EN)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_ok),
  .cs_n      (cs_n),
  .rw_n      (rw_n),
  .out_active(out_active)
);

// File: tb/test_scratch_ram.sv
module test_scratch_ram;
  import scratch_ram_pkg::*;

  logic clk;
  logic rst_n;

  logic [0:0] a_cs_n;
  logic       a_rw_n;
  logic [3:0] a_addr;
  logic [3:0] a_din;
  logic [3:0] a_dout;
  logic       a_act;

  logic [2:0] b_cs_n;
  logic       b_rw_n;
  logic [7:0] b_addr;
  logic [0:0] b_din;
  logic [0:0] b_dout;
  logic       b_act;

  logic [3:0] a_model [16];
  logic       b_model [256];

  int  n_chk;
  int  n_fail;
  bit  done;

  scratch_ram #(
    .ORG(ORG_16X4), .NUM_EN(1), .INVERT_RD(1'b1), .OPEN_DRAIN(1'b0)
  ) i_scratch_ram (
    .clk(clk), .rst_n(rst_n), .cs_n(a_cs_n), .rw_n(a_rw_n),
    .addr(a_addr), .din(a_din), .dout(a_dout), .out_active(a_act)
  );

  scratch_ram #(
    .ORG(ORG_256X1), .NUM_EN(3), .INVERT_RD(1'b0), .OPEN_DRAIN(1'b1)
  ) i_scratch_ram_w (
    .clk(clk), .rst_n(rst_n), .cs_n(b_cs_n), .rw_n(b_rw_n),
    .addr(b_addr), .din(b_din), .dout(b_dout), .out_active(b_act)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    a_cs_n = 1'b1; a_rw_n = 1'b1;
    b_cs_n = 3'b111; b_rw_n = 1'b1;
  endtask

  task automatic a_wr(input logic [3:0] ad, input logic [3:0] d);
    a_cs_n = 1'b0; a_rw_n = 1'b0; a_addr = ad; a_din = d;
    @(negedge clk);
    chk(a_act == 1'b0, "R4 16x4 off during write", a_act, 0);
    a_model[ad] = d;
  endtask

  task automatic a_rd(input logic [3:0] ad, input string req);
    a_cs_n = 1'b0; a_rw_n = 1'b1; a_addr = ad;
    @(negedge clk);
    chk(a_act == 1'b1, "R3 16x4 drives on read", a_act, 1);
    chk(a_dout == ~a_model[ad], req, a_dout, ~a_model[ad]);
  endtask

  task automatic b_wr(input logic [7:0] ad, input logic d);
    b_cs_n = 3'b000; b_rw_n = 1'b0; b_addr = ad; b_din = d;
    @(negedge clk);
    chk(b_act == 1'b0 && b_dout == 1'b1, "R4 R7 256x1 off-high during write", {b_act, b_dout}, 1);
    b_model[ad] = d;
  endtask

  task automatic b_rd(input logic [7:0] ad, input string req);
    b_cs_n = 3'b000; b_rw_n = 1'b1; b_addr = ad;
    @(negedge clk);
    chk(b_act == 1'b1, "R3 256x1 drives on read", b_act, 1);
    chk(b_dout == b_model[ad], req, b_dout, b_model[ad]);
  endtask

  // R1 R7: reset state of both builds
  task automatic t_reset();
    rst_n = 1'b0;
    idle_all();
    a_addr = '0; a_din = '0; b_addr = '0; b_din = '0;
    repeat (3) @(negedge clk);
    chk(a_act == 1'b0, "R1 16x4 off in reset", a_act, 0);
    chk(b_act == 1'b0 && b_dout == 1'b1, "R1 R7 256x1 off-high in reset", {b_act, b_dout}, 1);
    rst_n = 1'b1;
    a_cs_n = 1'b0; b_cs_n = 3'b000;
    @(negedge clk);
    chk(a_act == 1'b0 && b_act == 1'b0, "R1 still off during reset release", {a_act, b_act}, 0);
    idle_all();
    repeat (3) @(negedge clk);
  endtask

  // R8 R9 R6: back-to-back writes of every word, then read all
  task automatic t_a_pattern();
    for (int i = 0; i < 16; i++) a_wr(4'(i), 4'((i * 7 + 3) & 15));
    for (int i = 0; i < 16; i++) a_rd(4'(i), "R6 R8 R9 16x4 complement readback");
    idle_all();
    @(negedge clk);
    chk(a_act == 1'b0, "R10 16x4 off after deselect", a_act, 0);
  endtask

  // R5 R2: deselected write and selected read with new din leave contents
  task automatic t_a_blocked();
    logic [3:0] keep;
    keep = a_model[5];
    a_cs_n = 1'b1; a_rw_n = 1'b0; a_addr = 4'd5; a_din = ~keep;
    @(negedge clk);
    chk(a_act == 1'b0, "R5 16x4 off when deselected", a_act, 0);
    a_cs_n = 1'b0; a_rw_n = 1'b1; a_din = ~keep;
    @(negedge clk);
    chk(a_dout == ~keep, "R2 16x4 read does not write", a_dout, ~keep);
    a_rd(4'd5, "R5 16x4 deselected write ignored");
    idle_all();
    @(negedge clk);
  endtask

  // R10: exact one-clock latency
  task automatic t_a_latency();
    a_rd(4'd3, "R10 16x4 first read");
    a_addr = 4'd9;
    #2;
    chk(a_dout == ~a_model[3], "R10 16x4 holds before edge", a_dout, ~a_model[3]);
    @(negedge clk);
    chk(a_dout == ~a_model[9], "R10 16x4 new word after edge", a_dout, ~a_model[9]);
    a_wr(4'd9, 4'hA);
    a_rd(4'd9, "R2 R6 16x4 overwrite visible next cycle");
    idle_all();
    @(negedge clk);
  endtask

  // R5 R7: each select alone blocks a write
  task automatic t_b_enables();
    b_wr(8'h12, 1'b1);
    b_rd(8'h12, "R2 256x1 selected write");
    for (int e = 0; e < 3; e++) begin
      b_cs_n = 3'(1 << e); b_rw_n = 1'b0; b_addr = 8'h12; b_din = 1'b0;
      @(negedge clk);
      chk(b_act == 1'b0 && b_dout == 1'b1, "R5 R7 256x1 off-high with one select high", {b_act, b_dout}, 1);
      b_rd(8'h12, "R5 256x1 single select blocks write");
    end
    idle_all();
    @(negedge clk);
    chk(b_dout == 1'b1 && b_act == 1'b0, "R7 256x1 idle off level", {b_act, b_dout}, 1);
  endtask

  // R8 R9 R6: full matrix pattern, true polarity
  task automatic t_b_pattern();
    for (int i = 0; i < 256; i++) b_wr(8'(i), 1'(((i * 37) >> 3) ^ (i >> 7)));
    for (int i = 0; i < 256; i++) b_rd(8'(i), "R6 R8 R9 256x1 readback");
    idle_all();
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_a_pattern();
    t_a_blocked();
    t_a_latency();
    t_b_enables();
    t_b_pattern();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule